// File: doc/BRIEF.md
# Gene-Programmed Feed-Forward Logic Cell Array

The block is a grid of small combinational logic cells whose individual functions and whose wiring are both set by a single configuration word, the chromosome. The chromosome is captured in a register on a load strobe. From then on, the primary outputs follow the primary inputs through the configured cells without any further clocking. Each cell reads up to three operands. An operand can come from a primary input or from a cell in an earlier column. A five-bit function code picks one of twenty Boolean operations, and four of those are 2:1 multiplexers with optional input inversion.

The array is meant to sit beside a search engine that proposes chromosomes and scores them. The block itself performs no search. It evaluates whatever chromosome is loaded and raises a validity flag when every gene is legal. Any illegal gene forces the outputs to zero, so a broken candidate can never drive a stray value.

Node numbering is fixed. Primary inputs occupy nodes 0..N_IN-1. The cells follow in column-major order: the cell at column c, row r is node N_IN + c*ROWS + r.

Top module: `gene_logic_array`

## Requirements
- R1: The chromosome layout is fixed. Cell k (node N_IN+k) occupies bits [k*CELL_W +: CELL_W], where CELL_W = 3*CW+5 and CW = clog2(node count). Within a cell, operand a sits at offset 0, operand b at offset CW, operand c at offset 2*CW, and the function code at offset 3*CW. Output gene j sits at bits [NCELL*CELL_W + j*CW +: CW] and drives out_o[j].
- R2: Function codes 0 to 6 give, in order: constant 0, constant 1, a, b, NOT a, NOT b, and a AND b.
- R3: Code 7 is a AND NOT b, and code 8 is NOT a AND b. Code 9 is NOT a AND NOT b, code 10 is a XOR b, and code 11 is a XNOR b.
- R4: Code 12 is a OR b, code 13 is a OR NOT b, code 14 is NOT a OR b, and code 15 is NOT a OR NOT b.
- R5: Codes 16 to 19 are multiplexers that yield the a-side when c=0 and the b-side when c=1. Code 16 inverts neither side, code 17 inverts b, code 18 inverts a, and code 19 inverts both.
- R6: For codes 0 to 15 the operand-c gene is ignored. This covers both its value and its legality.
- R7: A function code above 19 clears valid_o and forces out_o to zero.
- R8: An operand gene is legal if it names a primary input, or a cell in column c-LEVELS_BACK up to column c-1 for a cell in column c. Any other used operand gene clears valid_o and forces out_o to zero.
- R9: An output gene that names an existing node routes that node to its output. A gene at or above the node count clears valid_o and forces out_o to zero.
- R10: Reset clears the chromosome to all zeros, which leaves valid_o=1 and every output equal to in_i[0]. A chromosome is captured on a clock edge with load_i=1 and held unchanged while load_i=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the chromosome register |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Capture chrom_i at the next rising edge |
| chrom_i | input | CHROM_W | Chromosome to load (110 bits by default) |
| in_i | input | N_IN | Primary inputs, nodes 0..N_IN-1 |
| out_o | output | N_OUT | Primary outputs selected by the output genes |
| valid_o | output | 1 | High when every used gene of the loaded chromosome is legal |

## Verification
Each of the twenty function codes is placed in the first cell, and all eight input combinations are applied. Each truth table therefore separates its code from every neighbour, including the swapped-operand pair 7 and 8 and the four multiplexer inversions. A one-bit full adder built from XOR, AND and a multiplexer is compared against arithmetic a+b+cin. This shows that cross-column routing and output selection compose as intended. A third-column cell is then pointed at a primary input, at the column just behind it, at a column outside the window, and at itself. These cases separate the legal reach from the levels-back and feed-forward violations. Finally, an out-of-range third gene is paired with a two-input code and then with a multiplexer code, which shows that the gene matters only where it is used.

// File: rtl/gla_pkg.sv
package gla_pkg;

  localparam int FN_W    = 5;
  localparam int FN_LAST = 19;

  typedef enum logic [FN_W-1:0] {
    FN_ZERO    = 5'd0,
    FN_ONE     = 5'd1,
    FN_A       = 5'd2,
    FN_B       = 5'd3,
    FN_NA      = 5'd4,
    FN_NB      = 5'd5,
    FN_AND     = 5'd6,
    FN_AND_NB  = 5'd7,
    FN_AND_NA  = 5'd8,
    FN_NOR     = 5'd9,
    FN_XOR     = 5'd10,
    FN_XNOR    = 5'd11,
    FN_OR      = 5'd12,
    FN_OR_NB   = 5'd13,
    FN_OR_NA   = 5'd14,
    FN_NAND    = 5'd15,
    FN_MUX     = 5'd16,
    FN_MUX_NB  = 5'd17,
    FN_MUX_NA  = 5'd18,
    FN_MUX_NAB = 5'd19
  } fn_code_e;

  // three-operand codes: only these consume the c gene
  function automatic logic fn_uses_c(input logic [FN_W-1:0] f);
    return (f >= FN_MUX) && (f <= FN_MUX_NAB);
  endfunction

  function automatic logic fn_legal(input logic [FN_W-1:0] f);
    return f <= 5'(FN_LAST);
  endfunction

  function automatic logic fn_eval(input logic [FN_W-1:0] f,
                                   input logic a, input logic b,
                                   input logic c);
    logic y;
    case (f)
      FN_ZERO:    y = 1'b0;
      FN_ONE:     y = 1'b1;
      FN_A:       y = a;
      FN_B:       y = b;
      FN_NA:      y = ~a;
      FN_NB:      y = ~b;
      FN_AND:     y = a & b;
      FN_AND_NB:  y = a & ~b;
      FN_AND_NA:  y = ~a & b;
      FN_NOR:     y = ~a & ~b;
      FN_XOR:     y = a ^ b;
      FN_XNOR:    y = ~(a ^ b);
      FN_OR:      y = a | b;
      FN_OR_NB:   y = a | ~b;
      FN_OR_NA:   y = ~a | b;
      FN_NAND:    y = ~a | ~b;
      FN_MUX:     y = c ? b : a;
      FN_MUX_NB:  y = c ? ~b : a;
      FN_MUX_NA:  y = c ? b : ~a;
      FN_MUX_NAB: y = c ? ~b : ~a;
      default:    y = 1'b0;
    endcase
    return y;
  endfunction

endpackage

// File: rtl/gla_chrom_reg.sv
module gla_chrom_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] q_r;
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q_r;
    if (load_i) q_nxt = d_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= q_nxt;
  end

  assign q_o = q_r;

  // R10: a strobe captures the presented chromosome
  p_load_take_r10: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (q_o == $past(d_i)));

  // R10: without a strobe the chromosome does not move
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(q_o));

endmodule

// File: rtl/gla_cell.sv
module gla_cell
  import gla_pkg::*;
#(
  parameter int N_IN        = 3,
  parameter int ROWS        = 2,
  parameter int COL         = 0,
  parameter int LEVELS_BACK = 1,
  parameter int CW          = 4,
  localparam int AVAIL      = N_IN + COL * ROWS
) (
  input  logic [AVAIL-1:0] avail_i,
  input  logic [CW-1:0]    gene_a_i,
  input  logic [CW-1:0]    gene_b_i,
  input  logic [CW-1:0]    gene_c_i,
  input  logic [FN_W-1:0]  fn_i,
  output logic             y_o,
  output logic             ok_o
);

  localparam int FIRST_COL = (COL > LEVELS_BACK) ? (COL - LEVELS_BACK) : 0;
  localparam int LO_NODE   = N_IN + FIRST_COL * ROWS;

  function automatic logic src_ok(input logic [CW-1:0] g);
    int gi;
    gi = int'(g);
    return (gi < N_IN) || ((gi >= LO_NODE) && (gi < AVAIL));
  endfunction

  function automatic logic src_pick(input logic [CW-1:0] g,
                                    input logic [AVAIL-1:0] v);
    logic s;
    s = 1'b0;
    for (int i = 0; i < AVAIL; i++) begin
      if (int'(g) == i) s = v[i];
    end
    return s;
  endfunction

  logic op_a, op_b, op_c;
  logic ok_a, ok_b, ok_c;

  always_comb begin
    op_a = src_pick(gene_a_i, avail_i);
    op_b = src_pick(gene_b_i, avail_i);
    op_c = src_pick(gene_c_i, avail_i);
    ok_a = src_ok(gene_a_i);
    ok_b = src_ok(gene_b_i);
    ok_c = fn_uses_c(fn_i) ? src_ok(gene_c_i) : 1'b1;
  end

  assign ok_o = ok_a & ok_b & ok_c & fn_legal(fn_i);
  assign y_o  = fn_eval(fn_i, op_a, op_b, op_c);

endmodule

// File: rtl/gla_out_sel.sv
module gla_out_sel #(
  parameter int NODES = 9,
  parameter int CW    = 4
) (
  input  logic [NODES-1:0] all_i,
  input  logic [CW-1:0]    gene_i,
  output logic             y_o,
  output logic             ok_o
);

  always_comb begin
    y_o = 1'b0;
    for (int i = 0; i < NODES; i++) begin
      if (int'(gene_i) == i) y_o = all_i[i];
    end
  end

  assign ok_o = int'(gene_i) < NODES;

endmodule

// File: rtl/gene_logic_array.sv
module gene_logic_array
  import gla_pkg::*;
#(
  parameter int N_IN        = 3,
  parameter int N_OUT       = 2,
  parameter int ROWS        = 2,
  parameter int COLS        = 3,
  parameter int LEVELS_BACK = 1,
  localparam int NCELL      = ROWS * COLS,
  localparam int NODES      = N_IN + NCELL,
  localparam int CW         = (NODES > 1) ? $clog2(NODES) : 1,
  localparam int CELL_W     = 3 * CW + FN_W,
  localparam int OUT_BASE   = NCELL * CELL_W,
  localparam int CHROM_W    = OUT_BASE + N_OUT * CW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic [CHROM_W-1:0] chrom_i,
  input  logic [N_IN-1:0]    in_i,
  output logic [N_OUT-1:0]   out_o,
  output logic               valid_o
);

  logic [CHROM_W-1:0] chrom_q;
  logic [NCELL-1:0]   cell_ok;
  logic [N_OUT-1:0]   sel_y;
  logic [N_OUT-1:0]   sel_ok;
  logic [NODES-1:0]   all_nodes;

  gla_chrom_reg #(.W(CHROM_W)) u_chrom (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load_i),
    .d_i    (chrom_i),
    .q_o    (chrom_q)
  );

  for (genvar c = 0; c < COLS; c++) begin : g_col
    localparam int AV = N_IN + c * ROWS;
    logic [AV-1:0]      avail;
    logic [ROWS-1:0]    col_y;
    logic [AV+ROWS-1:0] upto;

    if (c == 0) begin : g_first
      assign avail = in_i;
    end else begin : g_next
      assign avail = g_col[c-1].upto;
    end

    for (genvar r = 0; r < ROWS; r++) begin : g_row
      localparam int K    = c * ROWS + r;
      localparam int BASE = K * CELL_W;
      logic [CW-1:0]   ga;
      logic [FN_W-1:0] fn;

      assign ga = chrom_q[BASE +: CW];
      assign fn = chrom_q[BASE + 3*CW +: FN_W];

      gla_cell #(
        .N_IN        (N_IN),
        .ROWS        (ROWS),
        .COL         (c),
        .LEVELS_BACK (LEVELS_BACK),
        .CW          (CW)
      ) u_cell (
        .avail_i  (avail),
        .gene_a_i (ga),
        .gene_b_i (chrom_q[BASE + CW +: CW]),
        .gene_c_i (chrom_q[BASE + 2*CW +: CW]),
        .fn_i     (fn),
        .y_o      (col_y[r]),
        .ok_o     (cell_ok[K])
      );

      // R7: an undefined function code poisons the whole array
      p_bad_fn_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fn > 5'(FN_LAST)) |-> (!valid_o && (out_o == '0)));

      // R2: constant codes ignore every operand
      p_const_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fn <= 5'd1) |-> (col_y[r] == fn[0]));

      // R8: operand a reaching into its own column or beyond is rejected
      p_fwd_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((int'(ga) >= AV) && (int'(ga) < NODES)) |-> !valid_o);
    end

    assign upto = {col_y, avail};
  end

  assign all_nodes = g_col[COLS-1].upto;

  for (genvar j = 0; j < N_OUT; j++) begin : g_out
    logic [CW-1:0] og;
    assign og = chrom_q[OUT_BASE + j*CW +: CW];

    gla_out_sel #(.NODES(NODES), .CW(CW)) u_sel (
      .all_i  (all_nodes),
      .gene_i (og),
      .y_o    (sel_y[j]),
      .ok_o   (sel_ok[j])
    );

    // R9: an output gene past the last node is rejected
    p_out_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(og) >= NODES) |-> (!valid_o && (out_o == '0)));
  end

  assign valid_o = (&cell_ok) & (&sel_ok);
  assign out_o   = valid_o ? sel_y : '0;

endmodule

// File: tb/sim_gene_logic_array.sv
module sim_gene_logic_array;

  localparam int N_IN     = 3;
  localparam int N_OUT    = 2;
  localparam int ROWS     = 2;
  localparam int COLS     = 3;
  localparam int NCELL    = ROWS * COLS;
  localparam int NODES    = N_IN + NCELL;
  localparam int CW       = $clog2(NODES);
  localparam int CELL_W   = 3 * CW + 5;
  localparam int OUT_BASE = NCELL * CELL_W;
  localparam int CHROM_W  = OUT_BASE + N_OUT * CW;

  logic               clk;
  logic               rst_n;
  logic               load_i;
  logic [CHROM_W-1:0] chrom_i;
  logic [N_IN-1:0]    in_i;
  logic [N_OUT-1:0]   out_o;
  logic               valid_o;

  logic [CHROM_W-1:0] cfg;
  int n_chk = 0;
  int n_bad = 0;

  gene_logic_array u0 (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .chrom_i(chrom_i),
    .in_i(in_i), .out_o(out_o), .valid_o(valid_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got running expected finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  // R1 layout: operands at 0, CW, 2CW; function at 3CW
  task automatic put_cell(input int k, input int a, input int b, input int c, input int f);
    cfg[k*CELL_W +: CW]          = CW'(a);
    cfg[k*CELL_W + CW +: CW]     = CW'(b);
    cfg[k*CELL_W + 2*CW +: CW]   = CW'(c);
    cfg[k*CELL_W + 3*CW +: 5]    = 5'(f);
  endtask

  task automatic put_out(input int j, input int g);
    cfg[OUT_BASE + j*CW +: CW] = CW'(g);
  endtask

  task automatic load_cfg();
    @(negedge clk);
    chrom_i = cfg;
    load_i  = 1'b1;
    @(negedge clk);
    load_i  = 1'b0;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // reference truth from the code table in R2..R5
  function automatic bit ref_fn(input int f, input bit a, input bit b, input bit c);
    bit sa, sb;
    if (f >= 16) begin
      sa = (f == 18 || f == 19) ? !a : a;
      sb = (f == 17 || f == 19) ? !b : b;
      return c ? sb : sa;
    end
    case (f)
      0: return 0;
      1: return 1;
      2: return a;
      3: return b;
      4: return !a;
      5: return !b;
      6: return a && b;
      7: return a && !b;
      8: return b && !a;
      9: return !(a || b);
      10: return a != b;
      11: return a == b;
      12: return a || b;
      13: return a || !b;
      14: return b || !a;
      15: return !(a && b);
      default: return 0;
    endcase
  endfunction

  // {valid, out1, out0} observed at the ports
  function automatic logic [31:0] obs();
    return {29'd0, valid_o, out_o};
  endfunction

  task automatic build_adder();
    cfg = '0;
    put_cell(0, 0, 1, 0, 10);  // node 3: a^b
    put_cell(1, 0, 1, 0, 6);   // node 4: a&b
    put_cell(2, 3, 2, 0, 10);  // node 5: sum
    put_cell(3, 4, 2, 3, 16);  // node 6: carry
    put_out(0, 5);
    put_out(1, 6);
  endtask

  initial begin
    string tag;
    rst_n = 1'b0; load_i = 1'b0; chrom_i = '0; in_i = '0; cfg = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: reset chromosome routes node 0 to both outputs
    for (int v = 0; v < 8; v++) begin
      in_i = 3'(v); #1;
      check("R10 reset state", obs(), {29'd0, 1'b1, {2{v[0]}}});
    end

    // R2..R5: every function code in cell 0, all input patterns
    for (int f = 0; f < 20; f++) begin
      cfg = '0;
      put_cell(0, 0, 1, 2, f);
      put_out(0, 3);
      put_out(1, 1);
      load_cfg();
      tag = (f <= 6) ? "R2 code" : (f <= 11) ? "R3 code" : (f <= 15) ? "R4 code" : "R5 code";
      for (int v = 0; v < 8; v++) begin
        in_i = 3'(v); #1;
        check($sformatf("%s %0d in=%0d", tag, f, v), obs(),
              {29'd0, 1'b1, v[1], ref_fn(f, v[0], v[1], v[2])});
      end
    end

    // R1 / R5: full adder across two columns
    build_adder();
    load_cfg();
    for (int v = 0; v < 8; v++) begin
      in_i = 3'(v); #1;
      check("R1 adder", obs(), 32'(4 + v[0] + v[1] + v[2]));
    end

    // R8: third-column cell (node 7) reaching the previous column
    put_cell(4, 5, 6, 0, 6);
    put_out(0, 7);
    put_out(1, 1);
    load_cfg();
    for (int v = 0; v < 8; v++) begin
      in_i = 3'(v); #1;
      check("R8 window legal", obs(), {29'd0, 1'b1, v[1], (v == 7)});
    end

    // R8: primary input always reachable
    put_cell(4, 2, 5, 0, 6);
    load_cfg();
    for (int v = 0; v < 8; v++) begin
      in_i = 3'(v); #1;
      check("R8 input reach", obs(), {29'd0, 1'b1, v[1], bit'(v[2] && (v[0] ^ v[1] ^ v[2]))});
    end

    // R6: unused third gene out of range on a two-input code
    put_cell(4, 2, 5, 15, 6);
    load_cfg();
    for (int v = 0; v < 8; v++) begin
      in_i = 3'(v); #1;
      check("R6 c ignored", obs(), {29'd0, 1'b1, v[1], bit'(v[2] && (v[0] ^ v[1] ^ v[2]))});
    end

    // R6 / R8: same gene on a mux code is used and illegal
    put_cell(4, 2, 5, 15, 16);
    load_cfg();
    in_i = 3'd7; #1;
    check("R8 mux c illegal", obs(), 32'd0);

    // R8: two columns back exceeds the window of one
    put_cell(4, 3, 5, 0, 6);
    load_cfg();
    in_i = 3'd7; #1;
    check("R8 levels-back", obs(), 32'd0);

    // R8: self reference
    put_cell(4, 7, 5, 0, 6);
    load_cfg();
    in_i = 3'd3; #1;
    check("R8 self loop", obs(), 32'd0);

    // R8: same-column reference in column 0
    build_adder();
    put_cell(1, 3, 0, 0, 6);
    load_cfg();
    in_i = 3'd3; #1;
    check("R8 same column", obs(), 32'd0);

    // R7: undefined function codes
    build_adder();
    put_cell(0, 0, 1, 0, 20);
    load_cfg();
    in_i = 3'd1; #1;
    check("R7 code 20", obs(), 32'd0);
    put_cell(0, 0, 1, 0, 31);
    load_cfg();
    in_i = 3'd2; #1;
    check("R7 code 31", obs(), 32'd0);

    // R9: output routing and range
    build_adder();
    put_cell(5, 0, 0, 0, 1);   // node 8: constant 1
    put_out(0, 2);
    put_out(1, 8);
    load_cfg();
    for (int v = 0; v < 8; v++) begin
      in_i = 3'(v); #1;
      check("R9 route", obs(), {29'd0, 1'b1, 1'b1, v[2]});
    end
    put_out(1, 9);
    load_cfg();
    in_i = 3'd4; #1;
    check("R9 gene past nodes", obs(), 32'd0);

    // R10: chromosome held while load is low
    build_adder();
    load_cfg();
    @(negedge clk);
    chrom_i = '1;
    repeat (3) @(negedge clk);
    for (int v = 0; v < 8; v++) begin
      in_i = 3'(v); #1;
      check("R10 hold", obs(), 32'(4 + v[0] + v[1] + v[2]));
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule